// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a group of general-purpose input lines and records, per line, two independent events: the line went high and the line went low. The lines are grouped in banks of sixteen. One bank serves a 16-line build and two banks serve a 32-line build. Each bank has a 32-bit pending-status register and a 32-bit enable register. Both registers use the same bit layout. Rising flags for the bank's sixteen lines sit in bits 15:0, and falling flags for the same lines sit in bits 31:16.

Software services the block in a fixed sequence:

1. It reads a bank's pending status.
2. It qualifies that status with the enable register. It can read the AND of the two directly from a third view.
3. It clears what it handled by writing those bits back as ones.

A registered, active-high interrupt output is raised while any enabled pending bit is set in any bank. Every input passes through a two-flop synchroniser before edge detection.

The register port takes a valid strobe, a write flag, a 4-bit word address and 32-bit write data. Read data is returned one cycle after the request.

Address decoding:
- `reg_addr[3:2]` selects the bank.
- `reg_addr[1:0]` selects the view: 0 is raw status, 1 is enable, 2 is status AND enable, and 3 is unmapped.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Each input line passes through two synchroniser flops. A 0-to-1 transition of line n of bank b sets status bit n of that bank. A 1-to-0 transition sets bit n+16. The status bit is set three rising clock edges after the input changes.
- R2: In the second bank, lines 16 to 31 map to bits 15:0 (rising) and bits 31:16 (falling), with line 16+k at position k. This is the same layout as lines 0 to 15 in the first bank.
- R3: Status bits latch on edges whatever the enable setting. Masked events remain visible in the raw status view (view 0).
- R4: Writing view 0 clears exactly the status bits written as one. Bits written as zero keep their value.
- R5: If an edge sets a status bit in the same cycle that a write-one-to-clear targets that bit, the bit stays set.
- R6: Writing view 1 replaces the bank's enable register, which holds separate rising and falling enables per line. Enables change only through such writes, and an enable write never alters status.
- R7: Reading view 2 returns the bank's status AND enable.
- R8: `irq` is a registered OR, over all banks, of status AND enable. It follows a status or enable change by one cycle, and it is low whenever no enable bit is set.
- R9: After reset, all status bits, all enable bits, `irq` and `reg_rdata` are zero.
- R10: Reads of view 3, or of a bank index at or above NUM_BANKS, return zero. Writes to those addresses change nothing.
- R11: `reg_rdata` carries the addressed value in the cycle after a read request and is zero in the cycle after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lines_in | input | 16*NUM_BANKS | Asynchronous general-purpose input lines |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address {bank, view} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Registered interrupt, high while any enabled event is pending |

## Verification
A lost or phantom status bit shows up in the next read of view 0 or view 2. It also moves `irq` one cycle after the bad status appears. A corrupted enable bit stays invisible until a matching event is pending, unless view 1 is read back. For this reason the stimulus reads every view often and checks `irq` after every line change and every write.

A wrong priority between a clear and a simultaneous edge leaves only one trace: a bit that is missing when it should stay set. The edge-clear race is therefore driven cycle-exactly.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [16*NUM_BANKS-1:0] lines_in,
  input  logic                    reg_valid,
  input  logic                    reg_write,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    irq
);
  localparam int LINES = 16 * NUM_BANKS;
  localparam int RW    = 32 * NUM_BANKS;
  localparam int BW    = ADDR_W - 2;

  logic [LINES-1:0] sync1, sync2, prev;
  logic [RW-1:0]    stat_q, en_q, ev_w, clr_w;
  logic [BW-1:0]    bank_idx;
  logic [1:0]       view;
  logic [31:0]      rd_val;

  assign bank_idx = reg_addr[ADDR_W-1:2];
  assign view     = reg_addr[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= lines_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = reg_valid && reg_write && (bank_idx == BW'(b));
    assign ev_w[b*32 +: 32] = {prev[b*16 +: 16] & ~sync2[b*16 +: 16],
                               sync2[b*16 +: 16] & ~prev[b*16 +: 16]};
    assign clr_w[b*32 +: 32] = (hit && view == 2'd0) ? reg_wdata : 32'd0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        stat_q[b*32 +: 32] <= '0;
        en_q[b*32 +: 32]   <= '0;
      end else begin
        stat_q[b*32 +: 32] <= (stat_q[b*32 +: 32] & ~clr_w[b*32 +: 32]) | ev_w[b*32 +: 32];
        if (hit && view == 2'd1) en_q[b*32 +: 32] <= reg_wdata;
      end
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BW'(b))
        case (view)
          2'd0:    rd_val = stat_q[b*32 +: 32];
          2'd1:    rd_val = en_q[b*32 +: 32];
          2'd2:    rd_val = stat_q[b*32 +: 32] & en_q[b*32 +: 32];
          default: rd_val = '0;
        endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= (reg_valid && !reg_write) ? rd_val : 32'd0;
      irq       <= |(stat_q & en_q);
    end
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_valid,
  input logic                    reg_write,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [31:0]             reg_rdata,
  input logic                    irq,
  input logic [32*NUM_BANKS-1:0] stat_q,
  input logic [32*NUM_BANKS-1:0] en_q,
  input logic [32*NUM_BANKS-1:0] ev_w,
  input logic [32*NUM_BANKS-1:0] clr_w
);
  logic unmapped_rd;
  assign unmapped_rd = reg_valid && !reg_write &&
                       ((reg_addr[1:0] == 2'd3) || (int'(reg_addr[ADDR_W-1:2]) >= NUM_BANKS));

  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ev_w)) == '0)); // R1

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_w)) == '0)); // R4

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_w) & ~stat_q) == '0)); // R5

  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && reg_write) |=> $stable(en_q)); // R6

  AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq); // R8

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (reg_rdata == 32'd0)); // R10

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> (reg_rdata == 32'd0)); // R11
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq), .stat_q(stat_q),
  .en_q(en_q), .ev_w(ev_w), .clr_w(clr_w)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [16*NB-1:0] lines_in = '0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_stat [NB];
  logic [31:0] m_en [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    int b = int'(a[3:2]);
    if (b >= NB) return 32'd0;
    case (a[1:0])
      2'd0: return m_stat[b];
      2'd1: return m_en[b];
      2'd2: return m_stat[b] & m_en[b];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(m_stat[b] & m_en[b]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    check(req, reg_rdata, exp_read(a));
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    int b = int'(a[3:2]);
    if (b < NB) begin
      if (a[1:0] == 2'd0) m_stat[b] &= ~d;
      else if (a[1:0] == 2'd1) m_en[b] = d;
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input string req);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    model_write(a, d);
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic model_edges(input logic [31:0] oldv, input logic [31:0] newv);
    for (int b = 0; b < NB; b++)
      m_stat[b] |= {oldv[b*16 +: 16] & ~newv[b*16 +: 16], newv[b*16 +: 16] & ~oldv[b*16 +: 16]};
  endtask

  task automatic set_lines(input logic [31:0] newv, input string req);
    logic [31:0] oldv = lines_in;
    lines_in = newv;
    repeat (4) @(negedge clk);
    model_edges(oldv, newv);
    check(req, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    for (int b = 0; b < NB; b++) begin m_stat[b] = '0; m_en[b] = '0; end
    repeat (3) @(negedge clk);
    check("R9 rdata", reg_rdata, 32'd0);
    check("R9 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) do_read(4'(a), "R9 R10 reset read");

    // R1/R3: rise on line 3 with enables off
    set_lines(32'h0000_0008, "R3 irq masked");
    do_read(4'h0, "R1 R3 rise status");
    do_read(4'h2, "R7 masked view");
    // R6: enable rising line 3 only
    do_write(4'h1, 32'h0000_0008, "R8 irq on enable");
    do_read(4'h1, "R6 enable read");
    do_read(4'h0, "R6 status untouched");
    // R2: line 20 rise and fall in bank 1
    set_lines(32'h0010_0008, "R2 irq");
    set_lines(32'h0000_0008, "R2 irq");
    do_read(4'h4, "R2 bank1 status");
    // R10: writes to unmapped addresses
    do_write(4'h3, 32'hFFFF_FFFF, "R10 irq");
    do_write(4'h8, 32'hFFFF_FFFF, "R10 irq");
    do_write(4'hD, 32'hFFFF_FFFF, "R10 irq");
    for (int a = 0; a < 8; a++) do_read(4'(a), "R10 no effect");
    // R4: clear with zeros then partial
    do_write(4'h0, 32'h0, "R4 irq");
    do_read(4'h0, "R4 zero write");
    do_write(4'h4, 32'h0000_0010, "R4 irq");
    do_read(4'h4, "R4 partial clear");
    // R5: line 3 falls (bit 19), then rises again while clearing bits 3 and 19
    set_lines(32'h0000_0000, "R5 setup");
    do_read(4'h0, "R5 setup status");
    lines_in = 32'h0000_0008;
    @(negedge clk);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0008_0008;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    m_stat[0] = (m_stat[0] & ~32'h0008_0008) | 32'h0000_0008;
    @(negedge clk);
    do_read(4'h0, "R5 edge beats clear");
    check("R8 irq after race", {31'd0, irq}, {31'd0, exp_irq()});

    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 7));
      if (op <= 2) set_lines(lines_in ^ ($urandom & $urandom), "R1 R2 R8 random edges");
      else if (op == 3) do_write({2'($urandom_range(0, 3)), 2'd1}, $urandom, "R6 R8 random enable");
      else if (op == 4) begin
        logic [3:0] a = {2'($urandom_range(0, 1)), 2'd0};
        logic [31:0] d = $urandom[0] ? exp_read(a) : $urandom;
        do_write(a, d, "R4 R8 random clear");
      end else do_read(4'($urandom_range(0, 15)), "R3 R7 R11 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule